// File: doc/BRIEF.md
# Serial SAR Converter Acquisition Host

This block sits on the host side of a serial successive-approximation converter. It runs from one system clock and produces both converter control lines. A free-running binary counter produces the acquisition strobe `adc_sample`, and a tap of that counter selects one of two sample rates. A divider produces the converter bit clock `adc_clk`, and it is held in reset whenever the converter's BUSY line, brought into the system clock domain, is low. As a result the bit clock stays parked low through acquisition and at the falling edge of the strobe. The divider runs only while a conversion is under way.

Each conversion takes seventeen bit-clock pulses. The host ignores the falling edge of the first pulse. On the falling edges of pulses two to seventeen it shifts in sixteen serial bits, most significant first, and presents them as a signed two's-complement word with a single-cycle valid pulse. BUSY can drop right after the last rising edge, and the divider then forces the clock low early. That forced fall still counts as the final capture edge. A sticky flag records any new acquisition strobe that begins while the converter still reports busy.

Top module: `sar_acq_host`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `adc_sample`, `adc_clk`, `result_valid` and `overrun` are all 0.
- R2: `adc_sample` is a square wave. With `rate_sel`=0 its period is 2^(SMP_TAP+1) system cycles. With `rate_sel`=1 its period is 2^(SMP_TAP+2) system cycles.
- R3: While synchronized BUSY is low, `adc_clk` stays low. No rising edge of `adc_clk` occurs while `adc_sample` is high and the converter is idle.
- R4: While synchronized BUSY is high, `adc_clk` toggles every CLK_HALF system cycles, starting from low. Its high and low phases are therefore equal, so the low phase is at least half the period. One conversion sees exactly 17 rising edges while the converter is busy.
- R5: `adc_clk` is low at every falling edge of `adc_sample` that follows a completed conversion.
- R6: The falling edge of `adc_clk` pulse 1 captures nothing. Pulses 2 through 17 capture `adc_sdata` MSB first, one system cycle after the host drives the clock low. `result` equals the 16-bit word sent, read as two's complement (0x8000 = -32768, 0x7FFF = +32767).
- R7: `result_valid` is high for exactly one cycle per conversion, in the cycle after the 16th bit is captured.
- R8: `overrun` becomes 1 in the cycle in which `adc_sample` rises, if synchronized BUSY was high in the cycle before. It then stays 1 until reset. It stays 0 while every conversion ends before the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0 selects the fast sample tap, 1 selects the tap one bit higher (half rate) |
| adc_busy | input | 1 | Converter BUSY, asynchronous to the host |
| adc_sdata | input | 1 | Converter serial data |
| adc_sample | output | 1 | Acquisition strobe to the converter; its falling edge starts a conversion |
| adc_clk | output | 1 | Gated bit clock to the converter |
| result | output | DATA_W | Last converted word, signed |
| result_valid | output | 1 | One-cycle pulse marking a new `result` |
| overrun | output | 1 | Sticky flag: a strobe began while the converter was busy |

## Verification
The bench builds the block with SMP_TAP=6, CLK_HALF=1, SYNC_STAGES=2 and a 16-bit word. This gives strobe periods of 128 and 256 cycles. With a one-cycle clock half-period, a full 17-pulse conversion, including the BUSY synchronizer delay, fits inside the 64-cycle low phase of the fast strobe. The behavioural converter model can hold BUSY high for an extra span, so a strobe edge lands inside a conversion and the overrun path can be reached. The same settings keep extremes such as 0x8000 and 0x7FFF, and both rate taps, within a short run.

// File: rtl/sar_acq_pkg.sv
package sar_acq_pkg;
  localparam int unsigned DEF_DATA_W      = 16;
  localparam int unsigned DEF_SMP_TAP     = 6;
  localparam int unsigned DEF_CLK_HALF    = 1;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // number of bit-clock pulses a conversion consumes: one settling pulse plus one per bit
  function automatic int unsigned conv_pulses(input int unsigned data_w);
    return data_w + 1;
  endfunction
endpackage

// File: rtl/sar_acq_smp_gen.sv
module sar_acq_smp_gen #(
  parameter int unsigned SMP_TAP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  output logic sample_o,
  output logic sample_rise_o
);
  localparam int unsigned CNT_W = SMP_TAP + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             tap_bit;

  assign tap_bit       = rate_sel ? cnt_q[SMP_TAP+1] : cnt_q[SMP_TAP];
  assign sample_rise_o = tap_bit & ~sample_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sample_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      sample_o <= tap_bit;
    end
  end
endmodule

// File: rtl/sar_acq_clk_gate.sv
module sar_acq_clk_gate #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLK_HALF    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_a,
  output logic busy_s,
  output logic cclk_o,
  output logic fall_o
);
  localparam int unsigned DW = $clog2(CLK_HALF) + 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_HALF - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DW-1:0]          div_q;
  logic                   wrap;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], busy_a};
  end
  assign busy_s = sync_q[SYNC_STAGES-1];

  assign wrap = (div_q == LAST);

  // divider held in reset while the converter is idle
  always_ff @(posedge clk) begin
    if (rst || !busy_s) begin
      div_q  <= '0;
      cclk_o <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      cclk_o <= ~cclk_o;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // clock is about to go low, by toggle or by forced park
  assign fall_o = cclk_o & ~rst & (~busy_s | wrap);
endmodule

// File: rtl/sar_acq_deser.sv
module sar_acq_deser #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy_s,
  input  logic                     fall,
  input  logic                     sdata,
  output logic signed [DATA_W-1:0] data_o,
  output logic                     valid_o
);
  localparam int unsigned IW = $clog2(DATA_W + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W);

  logic              fall_d, busy_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_d  <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      fall_d  <= fall;
      busy_q  <= busy_s;
      valid_o <= 1'b0;
      if (busy_s && !busy_q) begin
        idx_q <= '0;
      end else if (fall_d && idx_q <= LAST_IDX) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q != '0) begin
          sh_q <= {sh_q[DATA_W-2:0], sdata};
          if (idx_q == LAST_IDX) begin
            data_o  <= $signed({sh_q[DATA_W-2:0], sdata});
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_acq_host.sv
module sar_acq_host
  import sar_acq_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SMP_TAP     = DEF_SMP_TAP,
  parameter int unsigned CLK_HALF    = DEF_CLK_HALF,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rate_sel,
  input  logic                     adc_busy,
  input  logic                     adc_sdata,
  output logic                     adc_sample,
  output logic                     adc_clk,
  output logic signed [DATA_W-1:0] result,
  output logic                     result_valid,
  output logic                     overrun
);
  logic smp_rise;
  logic busy_s;
  logic fall;

  sar_acq_smp_gen #(.SMP_TAP(SMP_TAP)) u_smp (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .sample_o(adc_sample), .sample_rise_o(smp_rise)
  );

  sar_acq_clk_gate #(.SYNC_STAGES(SYNC_STAGES), .CLK_HALF(CLK_HALF)) u_gate (
    .clk(clk), .rst(rst), .busy_a(adc_busy),
    .busy_s(busy_s), .cclk_o(adc_clk), .fall_o(fall)
  );

  sar_acq_deser #(.DATA_W(DATA_W)) u_deser (
    .clk(clk), .rst(rst), .busy_s(busy_s), .fall(fall), .sdata(adc_sdata),
    .data_o(result), .valid_o(result_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)                   overrun <= 1'b0;
    else if (smp_rise && busy_s) overrun <= 1'b1;
  end
endmodule

// File: rtl/sar_acq_host_chk.sv
module sar_acq_host_chk (
  input logic clk,
  input logic rst,
  input logic adc_sample,
  input logic adc_clk,
  input logic busy_s,
  input logic result_valid,
  input logic overrun
);
  p_clk_parked_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_s && !$past(busy_s)) |-> !adc_clk);

  p_clk_low_at_fall_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_sample) && !busy_s && !$past(busy_s)) |-> !adc_clk);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(adc_sample) && $past(busy_s)) |-> overrun);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind sar_acq_host sar_acq_host_chk u_chk (
  .clk(clk), .rst(rst), .adc_sample(adc_sample), .adc_clk(adc_clk),
  .busy_s(busy_s), .result_valid(result_valid), .overrun(overrun)
);

// File: tb/sar_acq_host_test.sv
module sar_acq_host_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b0;
  logic m_busy, m_sdata;
  logic adc_sample, adc_clk, result_valid, overrun;
  logic signed [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sar_acq_host uut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .adc_busy(m_busy), .adc_sdata(m_sdata),
    .adc_sample(adc_sample), .adc_clk(adc_clk), .result(result),
    .result_valid(result_valid), .overrun(overrun)
  );

  // behavioural converter
  logic [W-1:0] conv_word = 16'h0000;
  logic [W-1:0] shadow;
  logic [4:0]   pulses;
  logic         prev_s, prev_c;
  int           hold;
  int           stretch = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_sdata <= 1'b0; prev_s <= 1'b0; prev_c <= 1'b0;
      pulses <= '0; hold <= 0; shadow <= '0;
    end else begin
      prev_s <= adc_sample;
      prev_c <= adc_clk;
      if (!m_busy && prev_s && !adc_sample) begin
        m_busy <= 1'b1; pulses <= '0; shadow <= conv_word;
      end else if (m_busy) begin
        if (hold > 0) begin
          if (hold == 1) m_busy <= 1'b0;
          hold <= hold - 1;
        end else if (!prev_c && adc_clk) begin
          pulses <= pulses + 1'b1;
          if (pulses >= 5'd1) m_sdata <= shadow[4'(5'd16 - pulses)];
          if (pulses == 5'd16) begin
            if (stretch > 0) hold <= stretch;
            else m_busy <= 1'b0;
          end
        end
      end
    end
  end

  // monitors, sampled away from the active edge
  logic mon_s, mon_c;
  int acq_rises, bad_falls, max_high, run_high;
  always @(negedge clk) begin
    cycles <= cycles + 1;
    mon_s <= adc_sample;
    mon_c <= adc_clk;
    if (!rst) begin
      if (adc_clk && !mon_c && adc_sample) acq_rises <= acq_rises + 1;
      if (mon_s && !adc_sample && adc_clk) bad_falls <= bad_falls + 1;
      if (adc_clk) run_high <= run_high + 1;
      else if (run_high != 0) begin
        if (run_high > max_high) max_high <= run_high;
        run_high <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    acq_rises = 0; bad_falls = 0; max_high = 0;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (result_valid) begin got = 1; break; end
    end
  endtask

  task automatic sample_period(output int p);
    p = 0;
    for (int i = 0; i < 600 && !(adc_sample && !mon_s); i++) @(negedge clk);
    @(negedge clk); p = 1;
    for (int i = 0; i < 600 && !(adc_sample && !mon_s); i++) begin @(negedge clk); p++; end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!adc_sample && !adc_clk && !result_valid && !overrun, "R1 outputs in reset",
          {adc_sample, adc_clk, result_valid, overrun}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!adc_sample && !adc_clk && !result_valid && !overrun, "R1 outputs after reset",
          {adc_sample, adc_clk, result_valid, overrun}, 0);
  endtask

  task automatic t_rate(input logic sel, input int exp);
    int p;
    rate_sel = sel;
    sample_period(p);
    sample_period(p);
    check(p == exp, sel ? "R2 slow period" : "R2 fast period", p, exp);
  endtask

  task automatic t_convert(input logic [W-1:0] word);
    bit got;
    conv_word = word;
    wait_valid(got);
    clear_mon();
    wait_valid(got);
    check(got, "R7 valid seen", got, 1);
    check(result == $signed(word), "R6 result word", result, $signed(word));
    @(negedge clk);
    check(!result_valid, "R7 valid one cycle", result_valid, 0);
    check(acq_rises == 0, "R3 no clk rise during acquisition", acq_rises, 0);
    check(max_high == 1, "R4 clk high phase", max_high, 1);
    check(pulses == 5'd17, "R4 pulses per conversion", pulses, 17);
    check(bad_falls == 0, "R5 clk low at sample fall", bad_falls, 0);
  endtask

  task automatic t_overrun();
    int p;
    check(!overrun, "R8 no overrun on clean conversions", overrun, 0);
    stretch = 60;
    sample_period(p);
    sample_period(p);
    @(negedge clk);
    check(overrun, "R8 overrun set", overrun, 1);
    stretch = 0;
    repeat (300) @(negedge clk);
    check(overrun, "R8 overrun sticky", overrun, 1);
  endtask

  always @(negedge clk) begin
    if (!done && cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rate(1'b0, 128);
    t_rate(1'b1, 256);
    rate_sel = 1'b0;
    t_convert(16'hA5C3);
    t_convert(16'h8000);
    t_convert(16'h7FFF);
    t_convert(16'h0001);
    t_convert(16'hFFFF);
    t_convert(16'h0000);
    t_overrun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule